// File: doc/BRIEF.md
# Retrace-Synchronized Palette Fade Engine

This block owns a 256-colour palette, each colour made of red, green and blue components (768 bytes). Software first fills the palette through a preload port, then issues a start pulse with a fade step count. For every fade step the engine walks the whole palette once and lowers each component toward black, holding it at zero once it gets there. It then sends the new palette to a colour DAC that has an index register and a data register.

The transfer to the DAC is only allowed while the display is in vertical retrace, so that no palette change becomes visible in the middle of a frame. The engine reads one status bit for retrace. It waits until it has seen that bit outside retrace and then entering retrace again, which means it never uses a retrace period that was already running before it was ready. Each retrace carries half of the palette, 128 colours. When the last upload of the last fade step has finished, the engine raises a done pulse for one clock.

Top module: `pal_fade_engine`

## Requirements
- R1: After a synchronous active-low reset, `idx_wr_o`, `dat_wr_o` and `done_o` are 0 and the engine is idle.
- R2: Each fade step lowers every stored component by the parameter STEP (default 1). A component smaller than STEP becomes 0, and a component at 0 stays at 0. It never wraps.
- R3: Every upload begins with exactly one index write of value 0 on `idx_wr_o`/`idx_val_o`. This write happens in the clock just before the first data byte.
- R4: Data bytes leave in ascending byte-address order. Colour c occupies addresses 3c (red), 3c+1 (green) and 3c+2 (blue).
- R5: Retrace is bit 3 of `vstatus_i`, where 1 means retrace. A burst starts only after the engine, once ready, has seen that bit at 0 and then at 1. A retrace already in progress when the engine becomes ready is skipped. The other status bits have no effect.
- R6: Each burst is 384 bytes, one per clock with no gaps. One upload consists of two bursts in two separate retrace periods.
- R7: The number of fade steps, and so the number of uploads, equals `fade_steps_i` sampled with the accepted start pulse.
- R8: `done_o` is high for exactly one clock, the clock after the last data byte of the final upload.
- R9: While the engine is busy, a start pulse and a preload write are both ignored.
- R10: `idx_wr_o` and `dat_wr_o` are never high in the same clock. `dat_wr_o` is low outside bursts.
- R11: A preload write stores only the low 6 bits of `pl_data_i`. The upper 2 bits of the stored byte are 0.
- R12: A start pulse with `fade_steps_i` = 0 gives a `done_o` pulse in the next clock and no upload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for a fade |
| fade_steps_i | input | 9 | Number of fade steps, sampled on start |
| vstatus_i | input | 8 | Display status word; bit 3 is retrace |
| pl_we_i | input | 1 | Preload write enable |
| pl_addr_i | input | 10 | Preload byte address (0..767) |
| pl_data_i | input | 8 | Preload byte |
| idx_wr_o | output | 1 | DAC index write strobe |
| idx_val_o | output | 8 | DAC index value |
| dat_wr_o | output | 1 | DAC data write strobe |
| dat_val_o | output | 8 | DAC data byte |
| done_o | output | 1 | One-clock pulse at the end of the fade |

## Verification
The fade is run on three palettes:
- A scrambled ramp that holds every value from 0 to 63 in shuffled positions. This shows up both a decrement error and a byte-order error.
- A palette of only 0, 1 and 2 with the top bits set on preload. This exposes wrap-around at zero and a failure to mask the top bits.
- A further ramp that receives a start pulse and a preload write halfway through.

A run that begins with the retrace bit already high separates correct retrace gating from an engine that uses a retrace that is already running. A zero step count, and the quiet windows after the final upload, show whether the engine stops after exactly the number of steps it was asked for.

// File: rtl/pf_pkg.sv
// Package: shared types of the palette fade engine.
// Assumes: included first in compile order.
package pf_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DEC   = 3'd1,
        S_WAIT  = 3'd2,
        S_IDX   = 3'd3,
        S_BURST = 3'd4
    } pf_state_t;
endpackage

// File: rtl/pf_store.sv
// Module: palette byte store, one synchronous write port and one
// combinational read port.
// Assumes: the caller masks the write data and keeps the addresses in range.
module pf_store #(
    parameter int NBYTE = 768,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NBYTE];

    // Write one byte per clock.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read without delay, so one byte can be used in the same clock.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/pf_sat_dec.sv
// Module: saturating decrement of one palette component.
// Assumes: STEP is 1 or 2, and only the low CW bits of din carry the value.
module pf_sat_dec #(
    parameter int DW   = 8,
    parameter int CW   = 6,
    parameter int STEP = 1
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);
    logic [DW-1:0] val;

    // Clamp at zero instead of wrapping.
    always_comb begin
        val  = {{(DW-CW){1'b0}}, din[CW-1:0]};
        dout = (val >= STEP_V) ? (val - STEP_V) : '0;
    end
endmodule

// File: rtl/pf_retrace_gate.sv
// Module: retrace gate. After an arm pulse it waits until the retrace
// bit is low and then goes high again, and answers with a one-clock go.
// Assumes: rt is already synchronous to clk.
module pf_retrace_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rt,
    output logic go
);
    logic armed, seen_low;

    // Track the low-then-high sequence of the retrace bit after arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            seen_low <= 1'b0;
            go       <= 1'b0;
        end else begin
            go <= 1'b0;
            if (arm) begin
                armed    <= 1'b1;
                seen_low <= 1'b0;
            end else if (armed) begin
                if (!rt) begin
                    seen_low <= 1'b1;
                end else if (seen_low) begin
                    go    <= 1'b1;
                    armed <= 1'b0;
                end
            end
        end
    end

    // R5: go never follows arm directly, because a low must be seen first.
    a_r5_no_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !go);
    // R5: go is only raised after retrace was seen high.
    a_r5_go_in_retrace: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $past(rt));
endmodule

// File: rtl/pal_fade_engine.sv
// Module: palette fade engine (top). It holds a palette of NCOL colours x
// NCOMP components, lowers every component by STEP per fade step, and
// uploads the palette to a DAC index/data port in retrace bursts of
// PER_BURST colours.
// Assumes: vstatus_i is synchronous to clk, and each retrace lasts longer
// than one burst plus three clocks.
module pal_fade_engine #(
    parameter int NCOL      = 256,
    parameter int NCOMP     = 3,
    parameter int CW        = 6,
    parameter int BYTEW     = 8,
    parameter int PER_BURST = 128,
    parameter int STEP      = 1,
    parameter int STEPW     = 9,
    parameter int STATW     = 8,
    parameter int RT_BIT    = 3,
    localparam int NBYTE    = NCOL * NCOMP,
    localparam int AW       = $clog2(NBYTE),
    localparam int BBYTES   = PER_BURST * NCOMP,
    localparam int BCW      = $clog2(BBYTES),
    localparam int NBURST   = NCOL / PER_BURST,
    localparam int BIW      = (NBURST > 1) ? $clog2(NBURST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [STEPW-1:0] fade_steps_i,
    input  logic [STATW-1:0] vstatus_i,
    input  logic             pl_we_i,
    input  logic [AW-1:0]    pl_addr_i,
    input  logic [BYTEW-1:0] pl_data_i,
    output logic             idx_wr_o,
    output logic [BYTEW-1:0] idx_val_o,
    output logic             dat_wr_o,
    output logic [BYTEW-1:0] dat_val_o,
    output logic             done_o
);
    import pf_pkg::*;

    pf_state_t        state;
    logic [AW-1:0]    addr;
    logic [BCW-1:0]   bcnt;
    logic [BIW-1:0]   bidx;
    logic [STEPW-1:0] steps_left;
    logic             arm, go;
    logic             st_we;
    logic [AW-1:0]    st_waddr;
    logic [BYTEW-1:0] st_wdata, rd_q, dec_q;

    pf_store #(.NBYTE(NBYTE), .AW(AW), .DW(BYTEW)) u_store (
        .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .raddr(addr), .rdata(rd_q)
    );

    pf_sat_dec #(.DW(BYTEW), .CW(CW), .STEP(STEP)) u_dec (
        .din(rd_q), .dout(dec_q)
    );

    pf_retrace_gate u_gate (
        .clk(clk), .rst_n(rst_n), .arm(arm), .rt(vstatus_i[RT_BIT]), .go(go)
    );

    // Choose the write source: the decrement pass, or a preload only while idle.
    always_comb begin
        st_we    = 1'b0;
        st_waddr = pl_addr_i;
        st_wdata = {{(BYTEW-CW){1'b0}}, pl_data_i[CW-1:0]};
        if (state == S_DEC) begin
            st_we    = 1'b1;
            st_waddr = addr;
            st_wdata = dec_q;
        end else if (state == S_IDLE && pl_we_i && (pl_addr_i < AW'(NBYTE))) begin
            st_we = 1'b1;
        end
    end

    // Drive the DAC strobes from the state; the index value is always colour 0.
    always_comb begin
        idx_wr_o  = (state == S_IDX);
        idx_val_o = '0;
        dat_wr_o  = (state == S_BURST);
        dat_val_o = dat_wr_o ? rd_q : '0;
    end

    // Sequence: decrement pass, then for each burst wait for retrace, then send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            addr       <= '0;
            bcnt       <= '0;
            bidx       <= '0;
            steps_left <= '0;
            arm        <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            arm    <= 1'b0;
            done_o <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_i) begin
                        if (fade_steps_i == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            steps_left <= fade_steps_i;
                            addr       <= '0;
                            state      <= S_DEC;
                        end
                    end
                end
                S_DEC: begin
                    if (addr == AW'(NBYTE-1)) begin
                        addr  <= '0;
                        bidx  <= '0;
                        arm   <= 1'b1;
                        state <= S_WAIT;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (go) begin
                        bcnt  <= '0;
                        state <= (bidx == '0) ? S_IDX : S_BURST;
                    end
                end
                S_IDX: state <= S_BURST;
                S_BURST: begin
                    bcnt <= bcnt + 1'b1;
                    addr <= addr + 1'b1;
                    if (bcnt == BCW'(BBYTES-1)) begin
                        if (bidx == BIW'(NBURST-1)) begin
                            addr       <= '0;
                            steps_left <= steps_left - 1'b1;
                            if (steps_left == STEPW'(1)) begin
                                done_o <= 1'b1;
                                state  <= S_IDLE;
                            end else begin
                                state <= S_DEC;
                            end
                        end else begin
                            bidx  <= bidx + 1'b1;
                            arm   <= 1'b1;
                            state <= S_WAIT;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10: the two DAC strobes are never high in the same clock.
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_wr_o && dat_wr_o));
    // R3: the index write is followed directly by data.
    a_r3_idx_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr_o |=> dat_wr_o);
    // R8: done lasts one clock only.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2: the decrement never raises a component.
    a_r2_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEC) |-> (dec_q <= {{(BYTEW-CW){1'b0}}, rd_q[CW-1:0]}));
    // R2: a component at zero stays at zero.
    a_r2_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEC && rd_q[CW-1:0] == '0) |-> (dec_q == '0));
    // R7: a busy engine always has at least one step left.
    a_r7_steps_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (steps_left != '0));
    // R6: a burst ends only at a half-palette boundary.
    a_r6_burst_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_o && !idx_wr_o) |=> (dat_wr_o ||
            ($past(addr) == AW'(BBYTES-1)) || ($past(addr) == AW'(NBYTE-1))));
endmodule

// File: tb/pal_fade_engine_tb.sv
// Bench: directed scenarios for the palette fade engine. Each task checks its own results.
module pal_fade_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 768;
    localparam int HALF = 384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] fade_steps_i = '0;
    logic [7:0] vstatus_i = 8'hF7;
    logic       pl_we_i = 1'b0;
    logic [9:0] pl_addr_i = '0;
    logic [7:0] pl_data_i = '0;
    logic       idx_wr_o, dat_wr_o, done_o;
    logic [7:0] idx_val_o, dat_val_o;

    pal_fade_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fade_steps_i(fade_steps_i),
        .vstatus_i(vstatus_i), .pl_we_i(pl_we_i), .pl_addr_i(pl_addr_i),
        .pl_data_i(pl_data_i), .idx_wr_o(idx_wr_o), .idx_val_o(idx_val_o),
        .dat_wr_o(dat_wr_o), .dat_val_o(dat_val_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [NB];
    logic [7:0] cap [NB];
    int cap_n = 0, idx_cnt = 0, idx_bad = 0, order_bad = 0;
    int out_rt = 0, both_cnt = 0, done_cnt = 0, done_at = -1;
    logic idx_prev = 1'b0;

    // Monitor: record the DAC traffic at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (idx_wr_o && dat_wr_o) both_cnt++;
            if (idx_wr_o) begin
                idx_cnt++;
                if (idx_val_o != 8'd0) idx_bad++;
            end
            if (dat_wr_o) begin
                if (cap_n == 0 && !idx_prev) order_bad++;
                if (cap_n < NB) cap[cap_n] = dat_val_o;
                cap_n++;
                if (!vstatus_i[3]) out_rt++;
            end
            if (done_o) begin
                done_cnt++;
                done_at = cap_n;
            end
            idx_prev = idx_wr_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; idx_cnt = 0; idx_bad = 0; order_bad = 0;
        out_rt = 0; both_cnt = 0; done_cnt = 0; done_at = -1;
    endtask

    // Hold the retrace bit; the other status bits take the opposite value.
    task automatic rt_hold(input bit lvl, input int n);
        vstatus_i = lvl ? 8'h08 : 8'hF7;
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(input int kind);
        for (int i = 0; i < NB; i++) begin
            logic [7:0] v;
            case (kind)
                0: v = 8'((i * 37 + i / 3) % 64);
                1: v = 8'hC0 | 8'(i % 3);
                default: v = 8'((i * 11 + 5) % 64);
            endcase
            pl_we_i = 1'b1; pl_addr_i = 10'(i); pl_data_i = v;
            mdl[i] = v & 8'h3F;
            @(negedge clk);
        end
        pl_we_i = 1'b0;
    endtask

    task automatic pulse_start(input int steps);
        start_i = 1'b1; fade_steps_i = 9'(steps);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // One fade step: update the model, give two retraces, check the upload.
    task automatic run_step(input string tag, input bit last);
        int bad = 0, fa = 0, fe = 0;
        for (int k = 0; k < NB; k++) mdl[k] = (mdl[k] >= 8'd1) ? mdl[k] - 8'd1 : 8'd0;
        clear_mon();
        rt_hold(1'b0, 800);
        rt_hold(1'b1, 420);
        chk(cap_n == HALF, {tag, " R6 first burst length"}, cap_n, HALF);
        rt_hold(1'b0, 20);
        rt_hold(1'b1, 420);
        rt_hold(1'b0, 1);
        chk(cap_n == NB, {tag, " R6 upload length"}, cap_n, NB);
        chk(idx_cnt == 1 && idx_bad == 0, {tag, " R3 index write count"}, idx_cnt, 1);
        chk(order_bad == 0, {tag, " R3 index before data"}, order_bad, 0);
        for (int k = 0; k < NB; k++) if (cap[k] !== mdl[k]) begin
            if (bad == 0) begin fa = int'(cap[k]); fe = int'(mdl[k]); end
            bad++;
        end
        chk(bad == 0, {tag, " R2/R4 byte values in order"}, fa, fe);
        chk(out_rt == 0 && both_cnt == 0, {tag, " R10 strobes only in bursts"},
            out_rt + both_cnt, 0);
        if (last) chk(done_cnt == 1 && done_at == NB, {tag, " R8 done after last byte"},
                      done_at, NB);
        else chk(done_cnt == 0, {tag, " R8 no early done"}, done_cnt, 0);
    endtask

    task automatic quiet_check(input string tag);
        clear_mon();
        rt_hold(1'b0, 800); rt_hold(1'b1, 420); rt_hold(1'b0, 20); rt_hold(1'b1, 420);
        rt_hold(1'b0, 1);
        chk(cap_n == 0 && idx_cnt == 0 && done_cnt == 0, {tag, " R7 no extra upload"},
            cap_n, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(!idx_wr_o && !dat_wr_o && !done_o, "R1 outputs idle in reset",
            int'({idx_wr_o, dat_wr_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!idx_wr_o && !dat_wr_o && !done_o, "R1 outputs idle after reset",
            int'({idx_wr_o, dat_wr_o, done_o}), 0);
    endtask

    task automatic t_fade_ramp();
        preload(0);
        pulse_start(3);
        run_step("ramp s1", 1'b0);
        run_step("ramp s2", 1'b0);
        run_step("ramp s3", 1'b1);
        quiet_check("ramp");
    endtask

    task automatic t_saturate_mask();
        int bad = 0;
        preload(1);
        pulse_start(1);
        // R11: the top bits were dropped, so every byte after one step is at most 1.
        run_step("sat s1", 1'b1);
        for (int k = 0; k < NB; k++) if (cap[k] > 8'd1) bad++;
        chk(bad == 0, "R11 upper bits not stored", bad, 0);
        pulse_start(2);
        run_step("sat s2 R2 zero hold", 1'b0);
        run_step("sat s3 R2 zero hold", 1'b1);
    endtask

    task automatic t_busy_ignore();
        preload(2);
        rt_hold(1'b0, 1);
        pulse_start(2);
        repeat (100) @(negedge clk);
        start_i = 1'b1; fade_steps_i = 9'd5;
        pl_we_i = 1'b1; pl_addr_i = '0; pl_data_i = 8'h2A;
        @(negedge clk);
        start_i = 1'b0; pl_we_i = 1'b0;
        // R9: the busy start and the busy preload are expected to change nothing.
        run_step("busy s1 R9", 1'b0);
        run_step("busy s2 R9", 1'b1);
        quiet_check("busy R9");
    endtask

    task automatic t_zero_steps();
        clear_mon();
        pulse_start(0);
        chk(done_o == 1'b1, "R12 done next clock", int'(done_o), 1);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1 && cap_n == 0 && idx_cnt == 0, "R12 single done, no upload",
            done_cnt * 1000 + cap_n, 1000);
    endtask

    task automatic t_retrace_in_progress();
        preload(0);
        for (int k = 0; k < NB; k++) mdl[k] = (mdl[k] >= 8'd1) ? mdl[k] - 8'd1 : 8'd0;
        rt_hold(1'b1, 1);
        clear_mon();
        pulse_start(1);
        rt_hold(1'b1, 1200);
        chk(cap_n == 0 && idx_cnt == 0, "R5 running retrace skipped", cap_n + idx_cnt, 0);
        rt_hold(1'b0, 20);
        rt_hold(1'b1, 420);
        chk(cap_n == HALF, "R5 burst on next retrace", cap_n, HALF);
        rt_hold(1'b0, 20);
        rt_hold(1'b1, 420);
        rt_hold(1'b0, 1);
        chk(cap_n == NB && cap[0] == mdl[0] && cap[NB-1] == mdl[NB-1],
            "R5 full upload after gating", cap_n, NB);
        chk(done_cnt == 1, "R8 done in gated run", done_cnt, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fade_ramp();
        t_saturate_mask();
        t_busy_ignore();
        t_zero_steps();
        t_retrace_in_progress();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule